// File: doc/BRIEF.md
# Queued SPI Master with Per-Entry Command Words

This block is an SPI master that works through a preloaded list of up to 16 words without help from the host. Over a simple byte-wide register bus, the host fills three memories. The transmit memory holds the outgoing bytes. The command memory holds one byte per queue entry, which picks the chip-select line, says whether that line stays low into the next entry, and says whether the word length comes from the programmable bits-per-word field. The receive memory collects the incoming bytes. The host then sets a first and a last queue index and writes the run bit. The block shifts each entry out MSB first on MOSI while it samples MISO, and raises a done flag after the last entry.

The serial clock is the system clock divided by twice a baud value. The baud value is clamped to at least 8. All four CPOL/CPHA modes are supported. A global word-size bit selects 8-bit entries (one transmit byte each) or 16-bit entries (two consecutive transmit bytes each). A second control bit in the start write keeps the chip-select line low after the last entry, so that a following queue can extend the same transaction. If the run bit is cleared while the queue is active, the block stops at the next word boundary.

Register map (7-bit address): transmit bytes at 0x00 to 0x1F, command bytes at 0x20 to 0x2F, receive bytes at 0x40 to 0x5F. The registers are:
- 0x60: baud value
- 0x61: control byte (bit 7 master enable, bits 5:2 bits-per-word, bit 1 CPOL, bit 0 CPHA)
- 0x62: bit 0 selects 16-bit words
- 0x63: first index
- 0x64: last index
- 0x65: start/stop register (bit 6 run, bit 7 hold chip-select at the end)
- 0x66: status (bit 0 done, bit 1 busy)

Top module: `spi_cmdq_master`

## Requirements
- R1: After reset, every cs_n line is high, sck is low, the status register reads 0x00 and the baud register reads 8.
- R2: A baud write below 8 stores 8. Each sck half period lasts exactly baud system clocks.
- R3: Writing 0x65 with bit 6 set while idle and with master enable (0x61 bit 7) set runs the entries from the first index to the last index, inclusive and wrapping modulo 16. Status bit 1 reads 1 while the queue runs, and status bit 0 becomes 1 at the end. Writing 0 to 0x66 clears the done flag. If master enable is clear, the start write has no effect.
- R4: In 8-bit mode, entry i sends transmit byte i MSB first, and the byte received during entry i is stored at receive index i.
- R5: In 16-bit mode (0x62 bit 0 = 1), entry i sends transmit byte 2i followed by byte 2i+1, both MSB first. The received high byte is stored at receive index 2i and the low byte at 2i+1.
- R6: When command bit 6 is set, the entry length is the bits-per-word field, with 0 meaning 16. The bits sent are the top bits of the entry word. The received bits are right-aligned and zero-filled before they are stored as in R4 or R5.
- R7: When no queue is running, sck rests at CPOL. MOSI is stable on each sampling edge: the rising edge when CPOL equals CPHA, otherwise the falling edge.
- R8: Command bits 1:0 pick the single cs_n line driven low for the entry. With command bit 7 set, the line stays low into the next entry when that entry uses the same line. With bit 7 clear, every line goes high for at least one half period before the next entry.
- R9: With bit 7 of the start write set, the last entry's line stays low after done. A following queue on the same line starts without raising it. A queue started with bit 7 clear raises the line at its end.
- R10: Writing 0x65 with bit 6 clear during a run stops the queue after the word in progress. All cs_n lines go high, busy clears, and done stays 0.
- R11: While a queue runs, writes to the transmit and command memories, the baud register, the control byte, the word-size bit and the queue indices are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register bus write strobe |
| wr_addr | input | 7 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 7 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip-select lines |

## Verification
The hardest conditions to reach from the ports are those that depend on what happens between queues or inside a single word. One is a chip-select line that must stay low across the gap between two separate start writes. Another is a stop request that arrives in the middle of a word. The stimulus reaches the first by running a one-entry queue with the hold bit set and then a second queue on the same line, while a bench monitor counts every rising edge on cs_n. It reaches the second by writing the stop request a fixed 30 cycles into a 16-entry queue, then checking that the loopback slave captured exactly one word and that the next receive byte is unchanged. Random queues with wrapped index ranges, mixed word lengths and random modes, on top of these directed cases, compare every captured bit and its chip-select state against a model in the bench.

// File: rtl/spi_cmdq_master.sv
module spi_cmdq_master #(
  parameter int QDEPTH   = 16,
  parameter int NCS      = 4,
  parameter int BAUD_MIN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [6:0]     wr_addr,
  input  logic [7:0]     wr_data,
  input  logic [6:0]     rd_addr,
  output logic [7:0]     rd_data,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n
);
  localparam int QW = $clog2(QDEPTH);
  localparam int TW = QW + 1;
  localparam int SW = $clog2(NCS);
  localparam logic [7:0] BMIN = 8'(BAUD_MIN);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SHIFT, S_STORE, S_GAP} st_t;

  logic [7:0] tx_mem  [2*QDEPTH];
  logic [7:0] cmd_mem [QDEPTH];
  logic [7:0] rx_mem  [2*QDEPTH];

  st_t           state;
  logic [7:0]    baud, ctl, cnt;
  logic          wide, hold, done, abort, cs_on, sck_r, cur_cont;
  logic [QW-1:0] qstart, qend, ptr;
  logic [SW-1:0] cs_sel;
  logic [15:0]   sh_tx, sh_rx;
  logic [4:0]    nbits;
  logic [5:0]    edge_n;

  wire busy      = (state != S_IDLE);
  wire ram_we    = wr_en && !busy;
  wire tick      = (cnt == baud - 8'd1);
  wire last_edge = (edge_n == {nbits, 1'b0} - 6'd1);
  wire smp       = (edge_n[0] == ctl[0]);

  wire [15:0] ld_word = wide ? {tx_mem[{ptr, 1'b0}], tx_mem[{ptr, 1'b1}]}
                             : {tx_mem[TW'(ptr)], 8'h00};
  wire [4:0]  ld_bits = cmd_mem[ptr][6] ? ((ctl[5:2] == 4'd0) ? 5'd16 : {1'b0, ctl[5:2]})
                                        : (wide ? 5'd16 : 5'd8);

  assign sck  = sck_r ^ ctl[1];
  assign mosi = sh_tx[15];

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_n[g] = !(cs_on && cs_sel == SW'(g));
  end

  always_ff @(posedge clk) begin
    if (ram_we && wr_addr[6:5] == 2'b00) tx_mem[wr_addr[TW-1:0]] <= wr_data;
    if (ram_we && wr_addr[6:5] == 2'b01) cmd_mem[wr_addr[QW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (state == S_STORE) begin
      if (wide) begin
        rx_mem[{ptr, 1'b0}] <= sh_rx[15:8];
        rx_mem[{ptr, 1'b1}] <= sh_rx[7:0];
      end else begin
        rx_mem[TW'(ptr)] <= sh_rx[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; baud <= BMIN; ctl <= '0; cnt <= '0;
      wide <= 1'b0; hold <= 1'b0; done <= 1'b0; abort <= 1'b0;
      cs_on <= 1'b0; sck_r <= 1'b0; cur_cont <= 1'b0;
      qstart <= '0; qend <= '0; ptr <= '0; cs_sel <= '0;
      sh_tx <= '0; sh_rx <= '0; nbits <= 5'd8; edge_n <= '0;
    end else begin
      if (wr_en && wr_addr[6:5] == 2'b11) begin
        case (wr_addr[2:0])
          3'd0: if (!busy) baud <= (wr_data < BMIN) ? BMIN : wr_data;
          3'd1: if (!busy) ctl <= wr_data;
          3'd2: if (!busy) wide <= wr_data[0];
          3'd3: if (!busy) qstart <= wr_data[QW-1:0];
          3'd4: if (!busy) qend <= wr_data[QW-1:0];
          3'd5: begin
            if (wr_data[6]) begin
              if (!busy && ctl[7]) begin
                state <= S_LOAD; ptr <= qstart; hold <= wr_data[7]; abort <= 1'b0;
              end
            end else if (busy) abort <= 1'b1;
            else cs_on <= 1'b0;
          end
          3'd6: if (!wr_data[0]) done <= 1'b0;
          default: ;
        endcase
      end
      case (state)
        S_LOAD: begin
          sh_tx <= ld_word; sh_rx <= '0; nbits <= ld_bits;
          cs_sel <= cmd_mem[ptr][SW-1:0]; cur_cont <= cmd_mem[ptr][7];
          cs_on <= 1'b1; edge_n <= '0; cnt <= '0; sck_r <= 1'b0;
          state <= S_SHIFT;
        end
        S_SHIFT: begin
          if (tick) begin
            cnt <= '0; sck_r <= ~sck_r; edge_n <= edge_n + 6'd1;
            if (smp) sh_rx <= {sh_rx[14:0], miso};
            else if (edge_n != 6'd0) sh_tx <= {sh_tx[14:0], 1'b0};
            if (last_edge) state <= S_STORE;
          end else cnt <= cnt + 8'd1;
        end
        S_STORE: begin
          cnt <= '0;
          if (abort) begin
            state <= S_IDLE; cs_on <= 1'b0; abort <= 1'b0;
          end else if (ptr == qend) begin
            state <= S_IDLE; done <= 1'b1; cs_on <= hold;
          end else begin
            ptr <= ptr + QW'(1);
            if (cur_cont) state <= S_LOAD;
            else begin cs_on <= 1'b0; state <= S_GAP; end
          end
        end
        S_GAP: if (tick) state <= S_LOAD; else cnt <= cnt + 8'd1;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = 8'h00;
    case (rd_addr[6:5])
      2'b00: rd_data = tx_mem[rd_addr[TW-1:0]];
      2'b01: rd_data = cmd_mem[rd_addr[QW-1:0]];
      2'b10: rd_data = rx_mem[rd_addr[TW-1:0]];
      default:
        case (rd_addr[2:0])
          3'd0: rd_data = baud;
          3'd1: rd_data = ctl;
          3'd2: rd_data = {7'd0, wide};
          3'd3: rd_data = 8'(qstart);
          3'd4: rd_data = 8'(qend);
          3'd5: rd_data = {hold, busy, 6'd0};
          3'd6: rd_data = {6'd0, busy, done};
          default: rd_data = 8'h00;
        endcase
    endcase
  end

  a_r7_idle_sck: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (sck == ctl[1]));
  a_r7_word_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STORE) |-> (sck_r == 1'b0));
  a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT) |-> (cnt < baud));
  a_r8_gap_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_GAP) |-> (&cs_n));
  a_r3_start_at_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (ptr == qstart));
  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(wr_en && wr_addr == 7'h66 && !wr_data[0])) |=> done);
  a_r10_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STORE && abort) |=> (state == S_IDLE && (&cs_n) && !done));
  a_r11_tx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_addr == 7'h00) |=> $stable(tx_mem[0]));
endmodule

// File: tb/spi_cmdq_master_test.sv
`timescale 1ns/1ps
module spi_cmdq_master_test;
  localparam logic [6:0] A_BAUD = 7'h60, A_CTL = 7'h61, A_WIDE = 7'h62, A_QS = 7'h63,
                         A_QE = 7'h64, A_CTL2 = 7'h65, A_STAT = 7'h66;
  logic clk = 0, rst_n = 0, wr_en = 0, miso, sck, mosi;
  logic [6:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [3:0] cs_n;

  spi_cmdq_master uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  assign miso = mosi;
  always #2.5 clk = ~clk;

  int vec = 0, fail = 0;
  logic [7:0] tx_m [32];
  logic [7:0] cmd_m [16];
  logic [7:0] baud_m = 8, ctl_m = 0;
  logic wide_m = 0;
  int held = -1;

  logic slog [1024];
  logic [3:0] clog [1024];
  logic exp_b [1024];
  logic [3:0] exp_c [1024];
  int sn = 0, rises = 0;
  realtime te0 = 0, te1 = 0;
  logic [3:0] cs_prev = 4'hF;

  always @(sck) begin
    te0 = te1; te1 = $realtime;
    if (cs_n != 4'hF && sck == (ctl_m[1] == ctl_m[0])) begin
      if (sn < 1024) begin slog[sn] = mosi; clog[sn] = cs_n; end
      sn++;
    end
  end

  always @(cs_n) begin
    for (int k = 0; k < 4; k++) if (cs_prev[k] == 1'b0 && cs_n[k] == 1'b1) rises++;
    cs_prev = cs_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vec++;
    if (!ok) begin
      fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  task automatic cfg(input logic [7:0] b, input logic [7:0] c, input logic w);
    wr(A_BAUD, b); wr(A_CTL, c); wr(A_WIDE, {7'd0, w});
    baud_m = (b < 8) ? 8'd8 : b; ctl_m = c; wide_m = w;
  endtask

  task automatic ld_tx(input int i, input logic [7:0] v);
    wr(7'(i), v); tx_m[i] = v;
  endtask

  task automatic ld_cmd(input int i, input logic [7:0] v);
    wr(7'(8'h20 + i), v); cmd_m[i] = v;
  endtask

  function automatic int ebits(input int i);
    if (cmd_m[i][6]) return (ctl_m[5:2] == 0) ? 16 : int'(ctl_m[5:2]);
    return wide_m ? 16 : 8;
  endfunction

  function automatic logic [15:0] eword(input int i);
    return wide_m ? {tx_m[2*i], tx_m[2*i+1]} : {tx_m[i], 8'h00};
  endfunction

  task automatic wait_idle;
    logic [7:0] d;
    int k = 0;
    do begin rd(A_STAT, d); k++; end while (d[1] && k < 60000);
  endtask

  task automatic run_q(input int s, input int e, input bit hold, input bit poke, input string tag);
    int en = 0, r = 0, i = s, sel = 0, nb = 0, nc = 0;
    bit first = 1;
    logic [7:0] d;
    logic [15:0] v;
    while (1) begin
      logic [15:0] w = eword(i);
      int n = ebits(i);
      sel = int'(cmd_m[i][1:0]);
      if (first && held >= 0 && sel != held) r++;
      first = 0;
      for (int b = 0; b < n; b++) begin
        exp_b[en] = w[15-b]; exp_c[en] = ~(4'b1 << sel); en++;
      end
      if (i == e) break;
      if (!cmd_m[i][7]) r++;
      else if (int'(cmd_m[(i+1)%16][1:0]) != sel) r++;
      i = (i + 1) % 16;
    end
    if (!hold) r++;
    wr(A_QS, 8'(s)); wr(A_QE, 8'(e));
    sn = 0; rises = 0;
    wr(A_STAT, 8'h00);
    wr(A_CTL2, {hold, 7'h40});
    if (poke) begin
      wr(7'h00, ~tx_m[0]); wr(7'h20, 8'h00); wr(A_BAUD, 8'd40);
      wr(A_QE, 8'(s));
    end
    wait_idle;
    chk(sn == en, {tag, " bit count"}, sn, en);
    for (int k = 0; k < en && k < sn; k++) begin
      if (slog[k] !== exp_b[k]) nb++;
      if (clog[k] !== exp_c[k]) nc++;
    end
    chk(nb == 0, {tag, " serial bits"}, nb, 0);
    chk(nc == 0, {tag, " R8 chip-select per bit"}, nc, 0);
    chk(rises == r, {tag, " R8 cs rising edges"}, rises, r);
    rd(A_STAT, d);
    chk(d == 8'h01, {tag, " R3 done status"}, d, 1);
    i = s;
    while (1) begin
      v = eword(i) >> (16 - ebits(i));
      if (wide_m) begin
        rd(7'(8'h40 + 2*i), d);   chk(d == v[15:8], {tag, " R5 rx high"}, d, v[15:8]);
        rd(7'(8'h40 + 2*i+1), d); chk(d == v[7:0], {tag, " R5 rx low"}, d, v[7:0]);
      end else begin
        rd(7'(8'h40 + i), d);     chk(d == v[7:0], {tag, " R4 rx byte"}, d, v[7:0]);
      end
      if (i == e) break;
      i = (i + 1) % 16;
    end
    held = hold ? sel : -1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, fail);
    $finish;
  end

  initial begin
    logic [7:0] d, keep;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 4'hF, "R1 cs_n reset", cs_n, 15);
    chk(sck == 1'b0, "R1 sck reset", sck, 0);
    rd(A_STAT, d); chk(d == 8'h00, "R1 status reset", d, 0);
    rd(A_BAUD, d); chk(d == 8'd8, "R1 baud reset", d, 8);

    for (int i = 0; i < 32; i++) ld_tx(i, 8'(i * 37 + 5));
    for (int i = 0; i < 16; i++) ld_cmd(i, 8'h80);

    cfg(8'd3, 8'h80, 0);
    rd(A_BAUD, d); chk(d == 8'd8, "R2 baud clamp", d, 8);

    cfg(8'd10, 8'h80, 0);
    run_q(0, 0, 0, 0, "R2");
    chk(int'((te1 - te0) * 10) == 500, "R2 half period x10ns", int'((te1 - te0) * 10), 500);

    cfg(8'd8, 8'h00, 0);
    sn = 0;
    wr(A_STAT, 8'h00); wr(A_CTL2, 8'h40);
    repeat (5) @(negedge clk);
    rd(A_STAT, d); chk(d == 8'h00, "R3 start ignored without enable", d, 0);
    chk(sn == 0, "R3 no bits without enable", sn, 0);

    cfg(8'd8, 8'h80, 0);
    run_q(14, 1, 0, 0, "R3 wrap");
    wr(A_STAT, 8'h00);
    rd(A_STAT, d); chk(d == 8'h00, "R3 done cleared", d, 0);

    ld_tx(0, 8'h81); ld_tx(1, 8'h7E); ld_tx(2, 8'h00); ld_tx(3, 8'hFF);
    run_q(0, 3, 0, 0, "R4");

    for (int m = 0; m < 4; m++) begin
      cfg(8'd8, 8'h80 | 8'(m), 0);
      ld_tx(0, 8'hA5); ld_cmd(0, 8'h00);
      run_q(0, 0, 0, 0, "R7 mode");
      chk(sck == ctl_m[1], "R7 sck rest level", sck, ctl_m[1]);
    end

    cfg(8'd8, 8'h80, 1);
    ld_tx(0, 8'h12); ld_tx(1, 8'h34); ld_tx(2, 8'hAB); ld_tx(3, 8'hCD);
    ld_cmd(0, 8'h80); ld_cmd(1, 8'h80);
    run_q(0, 1, 0, 0, "R5");

    cfg(8'd8, 8'h80 | (8'd12 << 2), 1);
    ld_tx(0, 8'hF0); ld_tx(1, 8'h0F); ld_cmd(0, 8'hC0);
    run_q(0, 0, 0, 0, "R6");

    cfg(8'd8, 8'h80, 0);
    ld_cmd(0, 8'h00); ld_cmd(1, 8'h01); ld_cmd(2, 8'h02);
    run_q(0, 2, 0, 0, "R8");

    ld_cmd(5, 8'h01);
    run_q(5, 5, 1, 0, "R9 first");
    chk(cs_n == 4'b1101, "R9 line held after done", cs_n, 4'b1101);
    run_q(5, 5, 0, 0, "R9 second");
    chk(cs_n == 4'hF, "R9 line released", cs_n, 15);

    for (int i = 0; i < 16; i++) ld_cmd(i, 8'h80);
    ld_tx(0, 8'h3C);
    rd(7'h41, keep);
    wr(A_QS, 8'd0); wr(A_QE, 8'd15);
    sn = 0;
    wr(A_STAT, 8'h00); wr(A_CTL2, 8'h40);
    repeat (30) @(negedge clk);
    wr(A_CTL2, 8'h00);
    wait_idle;
    chk(sn == 8, "R10 one word after stop", sn, 8);
    rd(A_STAT, d); chk(d == 8'h00, "R10 done stays clear", d, 0);
    chk(cs_n == 4'hF, "R10 cs released", cs_n, 15);
    rd(7'h40, d); chk(d == 8'h3C, "R10 word in progress stored", d, 8'h3C);
    rd(7'h41, d); chk(d == keep, "R10 next entry untouched", d, keep);
    held = -1;

    ld_tx(0, 8'h5A); ld_tx(1, 8'hC3); ld_cmd(0, 8'h80); ld_cmd(1, 8'h80);
    run_q(0, 1, 0, 1, "R11");
    rd(7'h00, d); chk(d == 8'h5A, "R11 tx write ignored", d, 8'h5A);
    rd(7'h20, d); chk(d == 8'h80, "R11 cmd write ignored", d, 8'h80);
    rd(A_BAUD, d); chk(d == 8'd8, "R11 baud write ignored", d, 8);
    rd(A_QE, d); chk(d == 8'd1, "R11 index write ignored", d, 1);

    for (int t = 0; t < 12; t++) begin
      logic [3:0] bpw = 4'($urandom % 16);
      logic [1:0] md = 2'($urandom % 4);
      cfg(8'(8 + $urandom % 3), 8'h80 | {2'b00, bpw, md}, 1'($urandom % 2));
      for (int i = 0; i < 32; i++) ld_tx(i, 8'($urandom));
      for (int i = 0; i < 16; i++)
        ld_cmd(i, {1'($urandom % 2), ($urandom % 4) == 0, 4'd0, 2'($urandom % 4)});
      run_q(int'($urandom % 16), int'($urandom % 16), 0, 0, "R4 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, fail);
    $finish;
  end
endmodule